// File: doc/BRIEF.md
# Codec Input Line Steering

This block sits between the per-line slot decoders of a three-line audio codec link and the input DMA channels. Each input line delivers one slot per strobe. The slots are aligned across the lines, so one slot number and one strobe serve all three. Slot 0 of every frame is the tag slot. It carries the line's codec-ready flag and one valid flag for each data slot. The block latches these flags, then decides for each later data slot which input DMA channel gets a strobe and what data goes with it.

There are two channel pairs. Each pair has a PCM-in channel and a microphone channel. In merged mode, the lines whose codec is ready are ORed together, and only the first pair is fed. In steered mode, each pair takes its data and tags from one line, chosen by its own select field. The control word is sampled only at frame boundaries, so software can rewrite it at any time without splitting a frame.

Top module: `sdi_steer_top`

## Requirements
- R1: After reset every channel strobe and right flag is low and all channel data is zero. Data slots that arrive before the first tag slot produce no strobe.
- R2: A slot strobe with slot number 0 is the tag slot. On each line, tag bit 15 is codec-ready and bit (15 - s) is the valid flag for slot s (s = 1..12). The flags latched in a tag slot govern every data slot until the next tag slot.
- R3: In merged mode (`steer_ctl[0]` = 0), slots 3 and 4 strobe PCM channel 0 when any ready line has that slot's valid flag set. The data is the OR of the ready lines' slot data. `ch_right` is high only for slot 4.
- R4: In merged mode, slot 6 strobes microphone channel 1 under the same merging rule. The right flag of a microphone channel is never set.
- R5: A line whose latched codec-ready flag is clear adds nothing to the merged data or the merged valid flags.
- R6: In merged mode, channels 2 and 3 (the second pair) never strobe.
- R7: In steered mode (`steer_ctl[0]` = 1), pair 0 (channels 0 and 1) uses the line selected by `steer_ctl[2:1]`, and pair 1 (channels 2 and 3) uses the line selected by `steer_ctl[4:3]`. Only that line's data and valid flag count, and its ready flag is ignored.
- R8: A select value of 3 picks line 0.
- R9: `steer_ctl` is sampled only together with a tag slot. A change between tag slots has no effect on the current frame.
- R10: A channel output is a one-cycle pulse in the cycle after the slot strobe. Slots 1, 2, 5 and 7 to 12, and cycles without a strobe, produce no pulse. Channel data is zero whenever the channel's strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| steer_ctl | input | 5 | Bit 0 steer enable, [2:1] pair 0 line, [4:3] pair 1 line |
| slot_stb | input | 1 | A slot is present on all lines this cycle |
| slot_num | input | 4 | Slot number within the frame, 0 = tag slot |
| line_data | input | 60 | Slot contents, line L in bits [20L+19:20L] |
| ch_stb | output | 4 | Channel strobes: 0 PCM pair 0, 1 mic pair 0, 2 PCM pair 1, 3 mic pair 1 |
| ch_right | output | 4 | Per-channel flag: the strobe carries slot 4 |
| ch_data | output | 80 | Channel c data in bits [20c+19:20c] |

## Verification
The tag flags and the control word update at the clock edge that samples the tag slot. A data slot sampled at one edge shows up on the channel ports during the following cycle, and only during that cycle. The bench drives each slot on a falling edge and compares all four channels on the next falling edge, which is exactly one register stage later. At that same falling edge it drives the next slot. The bench's model latches ready flags, valid flags and the control word only when it issues a tag slot, the same way the block should. Control changes injected between tag slots, and idle cycles, are therefore checked against the older settings and against quiet outputs.

// File: rtl/sdi_steer_pkg.sv
package sdi_steer_pkg;

    // Slot numbering of one frame
    localparam int SLOT_NUM_W      = 4;
    localparam int TAG_VEC_W       = 2 ** SLOT_NUM_W;
    localparam int FIRST_DATA_SLOT = 1;
    localparam int LAST_DATA_SLOT  = 12;

    // Tag slot field: ready flag at the top, then one flag per data slot
    localparam int TAG_FIELD_W   = LAST_DATA_SLOT + 1;
    localparam int TAG_FIELD_LSB = 3;

    localparam logic [SLOT_NUM_W-1:0] SLOT_TAG   = 4'd0;
    localparam logic [SLOT_NUM_W-1:0] SLOT_PCM_L = 4'd3;
    localparam logic [SLOT_NUM_W-1:0] SLOT_PCM_R = 4'd4;
    localparam logic [SLOT_NUM_W-1:0] SLOT_MIC   = 4'd6;

    typedef logic [TAG_VEC_W-1:0] tag_vec_t;

    typedef struct packed {
        logic     ready;
        tag_vec_t valid;
    } tag_state_t;

endpackage

// File: rtl/sdi_tag_capture.sv
module sdi_tag_capture
    import sdi_steer_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tag_stb,
    input  logic [TAG_FIELD_W-1:0] tag_field,
    output logic                   ready_o,
    output tag_vec_t               valid_o
);

    tag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tag_stb) begin
            st_d.ready = tag_field[TAG_FIELD_W-1];
            st_d.valid = '0;
            for (int s = FIRST_DATA_SLOT; s <= LAST_DATA_SLOT; s++) begin
                st_d.valid[s] = tag_field[TAG_FIELD_W-1-s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = st_q.ready;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/sdi_cfg_latch.sv
module sdi_cfg_latch #(
    parameter int NUM_LINES = 3,
    parameter int NUM_PAIRS = 2,
    parameter int SEL_W     = 2,
    localparam int LSEL_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int CTL_W    = 1 + NUM_PAIRS * SEL_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [CTL_W-1:0]              ctl_in,
    output logic                          steer_en_o,
    output logic [NUM_PAIRS*LSEL_W-1:0]   line_sel_o
);

    typedef struct packed {
        logic                        en;
        logic [NUM_PAIRS*LSEL_W-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        logic [SEL_W-1:0] raw;
        cfg_d = cfg_q;
        raw   = '0;
        if (load) begin
            cfg_d.en = ctl_in[0];
            for (int p = 0; p < NUM_PAIRS; p++) begin
                raw = ctl_in[1 + p*SEL_W +: SEL_W];
                // out-of-range selects fall back to line 0
                if (int'(raw) >= NUM_LINES)
                    cfg_d.sel[p*LSEL_W +: LSEL_W] = '0;
                else
                    cfg_d.sel[p*LSEL_W +: LSEL_W] = LSEL_W'(raw);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign steer_en_o = cfg_q.en;
    assign line_sel_o = cfg_q.sel;

endmodule

// File: rtl/sdi_line_merge.sv
module sdi_line_merge
    import sdi_steer_pkg::*;
#(
    parameter int NUM_LINES = 3,
    parameter int SLOT_W    = 20
) (
    input  logic [NUM_LINES-1:0]           line_ready,
    input  logic [NUM_LINES*TAG_VEC_W-1:0] line_valid,
    input  logic [NUM_LINES*SLOT_W-1:0]    line_data,
    output logic [SLOT_W-1:0]              merged_data,
    output tag_vec_t                       merged_valid
);

    always_comb begin
        merged_data  = '0;
        merged_valid = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (line_ready[l]) begin
                merged_data  = merged_data  | line_data[l*SLOT_W +: SLOT_W];
                merged_valid = merged_valid | line_valid[l*TAG_VEC_W +: TAG_VEC_W];
            end
        end
    end

endmodule

// File: rtl/sdi_pair_route.sv
module sdi_pair_route
    import sdi_steer_pkg::*;
#(
    parameter int NUM_LINES = 3,
    parameter int SLOT_W    = 20,
    parameter int PAIR_IDX  = 0,
    parameter int LSEL_W    = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           slot_stb,
    input  logic [SLOT_NUM_W-1:0]          slot_num,
    input  logic                           steer_en,
    input  logic [LSEL_W-1:0]              line_sel,
    input  logic [NUM_LINES*SLOT_W-1:0]    line_data,
    input  logic [NUM_LINES*TAG_VEC_W-1:0] line_valid,
    input  logic [SLOT_W-1:0]              merged_data,
    input  tag_vec_t                       merged_valid,
    output logic                           pcm_stb,
    output logic                           pcm_right,
    output logic [SLOT_W-1:0]              pcm_data,
    output logic                           mic_stb,
    output logic [SLOT_W-1:0]              mic_data
);

    typedef struct packed {
        logic              pcm_stb;
        logic              pcm_right;
        logic [SLOT_W-1:0] pcm_data;
        logic              mic_stb;
        logic [SLOT_W-1:0] mic_data;
    } route_t;

    route_t st_d, st_q;

    logic [SLOT_W-1:0] src_data;
    tag_vec_t          src_valid;
    logic              active;
    logic              hit;

    always_comb begin
        if (steer_en) begin
            src_data  = line_data[int'(line_sel)*SLOT_W +: SLOT_W];
            src_valid = line_valid[int'(line_sel)*TAG_VEC_W +: TAG_VEC_W];
        end else begin
            src_data  = merged_data;
            src_valid = merged_valid;
        end
        active = steer_en || (PAIR_IDX == 0);
        hit    = slot_stb && active && src_valid[slot_num];
    end

    always_comb begin
        st_d = '0;
        if (hit && (slot_num == SLOT_PCM_L || slot_num == SLOT_PCM_R)) begin
            st_d.pcm_stb   = 1'b1;
            st_d.pcm_right = (slot_num == SLOT_PCM_R);
            st_d.pcm_data  = src_data;
        end
        if (hit && slot_num == SLOT_MIC) begin
            st_d.mic_stb  = 1'b1;
            st_d.mic_data = src_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pcm_stb   = st_q.pcm_stb;
    assign pcm_right = st_q.pcm_right;
    assign pcm_data  = st_q.pcm_data;
    assign mic_stb   = st_q.mic_stb;
    assign mic_data  = st_q.mic_data;

endmodule

// File: rtl/sdi_steer_top.sv
module sdi_steer_top
    import sdi_steer_pkg::*;
#(
    parameter int NUM_LINES = 3,
    parameter int NUM_PAIRS = 2,
    parameter int SLOT_W    = 20,
    parameter int SEL_W     = 2,
    localparam int LSEL_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int CTL_W    = 1 + NUM_PAIRS * SEL_W,
    localparam int NUM_CH   = 2 * NUM_PAIRS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CTL_W-1:0]            steer_ctl,
    input  logic                        slot_stb,
    input  logic [SLOT_NUM_W-1:0]       slot_num,
    input  logic [NUM_LINES*SLOT_W-1:0] line_data,
    output logic [NUM_CH-1:0]           ch_stb,
    output logic [NUM_CH-1:0]           ch_right,
    output logic [NUM_CH*SLOT_W-1:0]    ch_data
);

    logic                           tag_stb;
    logic [NUM_LINES-1:0]           line_ready;
    logic [NUM_LINES*TAG_VEC_W-1:0] line_valid;
    logic                           steer_en_w;
    logic [NUM_PAIRS*LSEL_W-1:0]    line_sel_w;
    logic [SLOT_W-1:0]              merged_data;
    tag_vec_t                       merged_valid;

    assign tag_stb = slot_stb && (slot_num == SLOT_TAG);

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        sdi_tag_capture u_tag (
            .clk       (clk),
            .rst_n     (rst_n),
            .tag_stb   (tag_stb),
            .tag_field (line_data[l*SLOT_W + TAG_FIELD_LSB +: TAG_FIELD_W]),
            .ready_o   (line_ready[l]),
            .valid_o   (line_valid[l*TAG_VEC_W +: TAG_VEC_W])
        );
    end

    sdi_cfg_latch #(
        .NUM_LINES (NUM_LINES),
        .NUM_PAIRS (NUM_PAIRS),
        .SEL_W     (SEL_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tag_stb),
        .ctl_in     (steer_ctl),
        .steer_en_o (steer_en_w),
        .line_sel_o (line_sel_w)
    );

    sdi_line_merge #(
        .NUM_LINES (NUM_LINES),
        .SLOT_W    (SLOT_W)
    ) u_merge (
        .line_ready   (line_ready),
        .line_valid   (line_valid),
        .line_data    (line_data),
        .merged_data  (merged_data),
        .merged_valid (merged_valid)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        sdi_pair_route #(
            .NUM_LINES (NUM_LINES),
            .SLOT_W    (SLOT_W),
            .PAIR_IDX  (p),
            .LSEL_W    (LSEL_W)
        ) u_route (
            .clk          (clk),
            .rst_n        (rst_n),
            .slot_stb     (slot_stb),
            .slot_num     (slot_num),
            .steer_en     (steer_en_w),
            .line_sel     (line_sel_w[p*LSEL_W +: LSEL_W]),
            .line_data    (line_data),
            .line_valid   (line_valid),
            .merged_data  (merged_data),
            .merged_valid (merged_valid),
            .pcm_stb      (ch_stb[2*p]),
            .pcm_right    (ch_right[2*p]),
            .pcm_data     (ch_data[(2*p)*SLOT_W +: SLOT_W]),
            .mic_stb      (ch_stb[2*p+1]),
            .mic_data     (ch_data[(2*p+1)*SLOT_W +: SLOT_W])
        );
        assign ch_right[2*p+1] = 1'b0;
    end

endmodule

// File: rtl/sdi_steer_checker.sv
module sdi_steer_checker #(
    parameter int NUM_PAIRS = 2,
    parameter int SLOT_W    = 20,
    localparam int NUM_CH   = 2 * NUM_PAIRS
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     slot_stb,
    input logic [3:0]               slot_num,
    input logic                     steer_en,
    input logic [NUM_CH-1:0]        ch_stb,
    input logic [NUM_CH-1:0]        ch_right,
    input logic [NUM_CH*SLOT_W-1:0] ch_data
);

    // R10: a pulse only follows a slot strobe
    assert_stb_follows_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_stb) |-> $past(slot_stb));

    // R10: only slots 3, 4 and 6 reach a channel
    assert_slot_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_stb) |-> ($past(slot_num) == 4'd3 || $past(slot_num) == 4'd4 ||
                       $past(slot_num) == 4'd6));

    // R6: second pair stays silent in merged mode
    assert_pair2_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(steer_en) |-> (ch_stb[NUM_CH-1:2] == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R10: data is quiet while the channel is idle
        assert_quiet_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_stb[c] |-> (ch_data[c*SLOT_W +: SLOT_W] == '0));
        if (c % 2 == 0) begin : g_pcm
            // R3: right flag marks a slot-4 pulse
            assert_right_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ch_right[c] |-> (ch_stb[c] && $past(slot_num) == 4'd4));
        end else begin : g_mic
            // R4: microphone channels never flag right
            assert_mic_no_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !ch_right[c]);
        end
    end

endmodule

bind sdi_steer_top sdi_steer_checker #(
    .NUM_PAIRS (NUM_PAIRS),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_stb (slot_stb),
    .slot_num (slot_num),
    .steer_en (steer_en_w),
    .ch_stb   (ch_stb),
    .ch_right (ch_right),
    .ch_data  (ch_data)
);

// File: tb/tb_sdi_steer_top.sv
`timescale 1ns/1ps
module tb_sdi_steer_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  steer_ctl = '0;
    logic        slot_stb = 1'b0;
    logic [3:0]  slot_num = '0;
    logic [59:0] line_data = '0;
    logic [3:0]  ch_stb;
    logic [3:0]  ch_right;
    logic [79:0] ch_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdi_steer_top dut (
        .clk(clk), .rst_n(rst_n), .steer_ctl(steer_ctl),
        .slot_stb(slot_stb), .slot_num(slot_num), .line_data(line_data),
        .ch_stb(ch_stb), .ch_right(ch_right), .ch_data(ch_data)
    );

    // bench model state, loaded only by tag slots
    bit        m_en;
    int        m_sel [2];
    bit        m_rdy [3];
    bit [15:0] m_tag [3];

    function automatic bit [21:0] exp_ch(int c, bit stb, bit [3:0] num, bit [59:0] d);
        int  p   = c / 2;
        bit  mic = c[0];
        bit  ok  = mic ? (num == 6) : (num == 3 || num == 4);
        bit  v   = 0;
        bit [19:0] dat = '0;
        if (!stb || !ok) return '0;
        if (!m_en) begin
            if (p != 0) return '0;
            for (int l = 0; l < 3; l++)
                if (m_rdy[l]) begin
                    v   = v | m_tag[l][num];
                    dat = dat | d[l*20 +: 20];
                end
        end else begin
            v   = m_tag[m_sel[p]][num];
            dat = d[m_sel[p]*20 +: 20];
        end
        if (!v) return '0;
        return {1'b1, (!mic && num == 4), dat};
    endfunction

    function automatic string req_of(int c, bit [3:0] num);
        if (!(num == 3 || num == 4 || num == 6)) return "R10";
        if (m_en) return "R7";
        if (c >= 2) return "R6";
        return c[0] ? "R4" : "R3";
    endfunction

    task automatic check(string rq, bit [63:0] got, bit [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", rq, got, exp);
        end
    endtask

    task automatic do_slot(bit stb, bit [3:0] num, bit [59:0] d, bit [4:0] ctl, string rq);
        bit [21:0] e [4];
        slot_stb  = stb;
        slot_num  = num;
        line_data = d;
        steer_ctl = ctl;
        for (int c = 0; c < 4; c++) e[c] = exp_ch(c, stb, num, d);
        @(posedge clk);
        if (stb && num == 0) begin
            m_en = ctl[0];
            for (int p = 0; p < 2; p++) begin
                m_sel[p] = int'(ctl[1+2*p +: 2]);
                if (m_sel[p] == 3) m_sel[p] = 0;
            end
            for (int l = 0; l < 3; l++) begin
                m_rdy[l] = d[l*20 + 15];
                m_tag[l] = '0;
                for (int s = 1; s <= 12; s++) m_tag[l][s] = d[l*20 + 15 - s];
            end
        end
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            check((rq != "") ? rq : req_of(c, num),
                  64'({ch_stb[c], ch_right[c], ch_data[c*20 +: 20]}), 64'(e[c]));
        end
    endtask

    function automatic bit [59:0] rand60();
        return {28'($urandom), $urandom};
    endfunction

    initial begin
        void'($urandom(32'h5EED));
        m_en = 0;
        for (int i = 0; i < 3; i++) begin m_rdy[i] = 0; m_tag[i] = '0; end
        m_sel[0] = 0; m_sel[1] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, no strobe before any tag slot
        check("R1", 64'({ch_stb, ch_right, ch_data}), 64'd0);
        do_slot(1, 4'd3, {3{20'hFFFFF}}, 5'd0, "R1");
        do_slot(1, 4'd6, {3{20'hFFFFF}}, 5'd0, "R1");
        // R2: line 0 ready with only slot 3 valid
        do_slot(1, 4'd0, {20'h0, 20'h0, 20'h09000}, 5'd0, "R2");
        do_slot(1, 4'd3, {20'h0, 20'h0, 20'h12345}, 5'd0, "R2");
        do_slot(1, 4'd4, {20'h0, 20'h0, 20'h12345}, 5'd0, "R2");
        // R5: line 1 not ready but tagged everywhere
        do_slot(1, 4'd0, {20'h0, 20'h07FF8, 20'h0D800}, 5'd0, "R5");
        do_slot(1, 4'd3, {20'h0, 20'hF0000, 20'h00F0F}, 5'd0, "R5");
        do_slot(1, 4'd6, {20'h0, 20'hF0000, 20'h00F0F}, 5'd0, "R5");
        // R8: pair 0 select 3 -> line 0, pair 1 select 1
        do_slot(1, 4'd0, {20'h0, 20'h01000, 20'h01000}, 5'b01_11_1, "R8");
        do_slot(1, 4'd3, {20'hAAAAA, 20'h55555, 20'h13579}, 5'b01_11_1, "R8");
        // R9: control change mid-frame is ignored
        do_slot(1, 4'd0, {20'h01800, 20'h0, 20'h0}, 5'b00_10_1, "R9");
        do_slot(1, 4'd4, {20'h2468A, 20'h0, 20'h11111}, 5'b00_00_0, "R9");
        do_slot(0, 4'd3, {20'h2468A, 20'h0, 20'h11111}, 5'b00_00_0, "R10");
        // random frames
        for (int f = 0; f < 400; f++) begin
            bit [4:0] ctl = 5'($urandom);
            bit [59:0] tg = rand60();
            for (int l = 0; l < 3; l++) tg[l*20 + 15] = ($urandom % 4) != 0;
            do_slot(1, 4'd0, tg, ctl, "");
            for (int s = 1; s <= 12; s++) begin
                if ($urandom % 8 == 0)
                    do_slot(0, 4'($urandom), rand60(), 5'($urandom), "R10");
                do_slot(1, 4'(s), rand60(), ($urandom % 4 == 0) ? 5'($urandom) : ctl, "");
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule